// File: doc/BRIEF.md
# Wireless MAC Header Parser and Destination Filter

The block parses the header of a received low-rate wireless personal-area-network MAC frame. Octets come in one per accepted cycle, and a start strobe marks the first octet of each frame. The parser decodes the two-octet frame control field and keeps the sequence number so that it can be copied into an acknowledgment. It then uses the two address-mode subfields and the intra-PAN bit to size the addressing fields, which vary in length. It checks the destination PAN ID and the destination device address against the locally configured identities.

When the last header octet has been consumed, a one-cycle done strobe is raised. The result outputs then hold the accept or reject verdict, a flag for a reserved address mode, an acknowledgment-needed flag and the octet offset at which the payload starts. These outputs stay unchanged until the next start strobe, however many payload octets follow. A start strobe in the middle of a frame abandons that frame and begins parsing a new one.

Top module: `mac_hdr_filter`

## Requirements
- R1: After reset, done, hdr_ok, mode_err and ack_needed are 0.
- R2: Octet 0 is the low byte of the frame control field and octet 1 is its high byte. The decoded outputs are: frame_type from bits [2:0], ack_req from bit 5, intra_pan from bit 6, dst_mode from bits [11:10] and src_mode from bits [15:14].
- R3: seq_num shows octet 2 of the frame.
- R4: The header is 3 octets plus a destination part and a source part. The destination part is 0 octets for mode 0, 4 for mode 2 and 10 for mode 3. The source part is sized the same way, less 2 octets when intra_pan is set and both modes are nonzero. Multi-octet values arrive least significant octet first, and a present address is its PAN ID followed by the device address. done is high for exactly one cycle, the cycle after the last header octet is accepted. payload_off then equals the header length.
- R5: If either mode is 1, mode_err is set, the frame is rejected and the header is taken to end at octet 2, so payload_off is 3.
- R6: With a destination present, the destination PAN ID must equal local_pan or 0xFFFF.
- R7: A short destination address must equal local_short or 0xFFFF. An extended destination address must equal local_ext.
- R8: With both modes 0, the frame is accepted only when frame_type is 2 (acknowledgment). With destination mode 0 and a source present, the frame is accepted.
- R9: ack_needed is high exactly when the frame is accepted and ack_req is set.
- R10: A start strobe accepted with in_valid begins a new frame. In the following cycle, hdr_ok and mode_err are 0 and done is 0, even if the earlier frame was left incomplete.
- R11: Cycles with in_valid low are skipped. Octets after the header do not change any result until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the octet on in_byte as the first of a frame |
| in_valid | input | 1 | in_byte holds an octet this cycle |
| in_byte | input | 8 | Received octet |
| local_pan | input | 16 | Local PAN identifier |
| local_short | input | 16 | Local short address |
| local_ext | input | 64 | Local extended address |
| done | output | 1 | One-cycle strobe when the header is complete |
| hdr_ok | output | 1 | Frame accepted by the filter |
| mode_err | output | 1 | A reserved address mode was seen |
| frame_type | output | 3 | Frame type from the control field |
| ack_req | output | 1 | Acknowledgment-request bit |
| ack_needed | output | 1 | Accepted frame that requests an acknowledgment |
| intra_pan | output | 1 | Intra-PAN bit |
| dst_mode | output | 2 | Destination address mode |
| src_mode | output | 2 | Source address mode |
| seq_num | output | 8 | Sequence number |
| payload_off | output | 5 | Octet index where the payload begins |

## Verification
An octet driven between clock edges is registered at the next rising edge. The done strobe and the verdict are therefore visible in the cycle after the last header octet, and the bench samples them exactly there: at the falling edge that follows that octet, before it drives anything else. The bench then confirms that done has dropped one cycle later. It sends payload octets with random gaps and checks that every result still holds. The clearing that follows a start strobe is sampled at the first falling edge after the strobed octet.

// File: rtl/mac_hdr_filter.sv
module mac_hdr_filter #(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [15:0]      local_pan,
  input  logic [15:0]      local_short,
  input  logic [63:0]      local_ext,
  output logic             done,
  output logic             hdr_ok,
  output logic             mode_err,
  output logic [2:0]       frame_type,
  output logic             ack_req,
  output logic             ack_needed,
  output logic             intra_pan,
  output logic [1:0]       dst_mode,
  output logic [1:0]       src_mode,
  output logic [7:0]       seq_num,
  output logic [OFF_W-1:0] payload_off
);

  logic [15:0] fcf, dpan;
  logic [63:0] daddr;
  logic [7:0]  seq;
  logic [OFF_W-1:0] cnt, dlen, slen_full, slen, hdr_len, dend;
  logic active, fin, bad, pan_ok, addr_ok;
  logic [2:0] didx;

  assign frame_type = fcf[2:0];
  assign ack_req    = fcf[5];
  assign intra_pan  = fcf[6];
  assign dst_mode   = fcf[11:10];
  assign src_mode   = fcf[15:14];
  assign seq_num    = seq;

  assign bad       = (dst_mode == 2'd1) || (src_mode == 2'd1);
  assign dlen      = (dst_mode == 2'd2) ? OFF_W'(4) : (dst_mode == 2'd3) ? OFF_W'(10) : '0;
  assign slen_full = (src_mode == 2'd2) ? OFF_W'(4) : (src_mode == 2'd3) ? OFF_W'(10) : '0;
  assign slen      = (intra_pan && dst_mode != 2'd0 && src_mode != 2'd0) ? slen_full - OFF_W'(2) : slen_full;
  assign hdr_len   = bad ? OFF_W'(3) : OFF_W'(3) + dlen + slen;
  assign dend      = (dst_mode == 2'd2) ? OFF_W'(7) : OFF_W'(13);
  assign didx      = cnt[2:0] - 3'd5;

  assign pan_ok  = (dpan == local_pan) || (dpan == 16'hFFFF);
  assign addr_ok = (dst_mode == 2'd2) ? (daddr[15:0] == local_short || daddr[15:0] == 16'hFFFF)
                                      : (daddr == local_ext);

  assign mode_err    = fin && bad;
  assign hdr_ok      = fin && !bad &&
                       ((dst_mode == 2'd0) ? (src_mode != 2'd0 || frame_type == 3'd2) : (pan_ok && addr_ok));
  assign ack_needed  = hdr_ok && ack_req;
  assign payload_off = hdr_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcf <= '0; seq <= '0; dpan <= '0; daddr <= '0;
      cnt <= '0; active <= 1'b0; fin <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid && sof) begin
        fcf <= {8'h00, in_byte};
        seq <= '0; dpan <= '0; daddr <= '0;
        cnt <= OFF_W'(1);
        active <= 1'b1;
        fin <= 1'b0;
      end else if (in_valid && active) begin
        cnt <= cnt + OFF_W'(1);
        if (cnt == OFF_W'(1)) fcf[15:8] <= in_byte;
        if (cnt == OFF_W'(2)) seq <= in_byte;
        if (!bad && dst_mode != 2'd0) begin
          if (cnt == OFF_W'(3)) dpan[7:0]  <= in_byte;
          if (cnt == OFF_W'(4)) dpan[15:8] <= in_byte;
          if (cnt >= OFF_W'(5) && cnt < dend) daddr[{didx, 3'b000} +: 8] <= in_byte;
        end
        if (cnt >= OFF_W'(2) && cnt == hdr_len - OFF_W'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
          done   <= 1'b1;
        end
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!active && payload_off >= OFF_W'(3) && payload_off <= OFF_W'(23)));
  // R3
  seq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sof && active && cnt == OFF_W'(2)) |=> (seq_num == $past(in_byte)));
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sof) |=> (!done && !hdr_ok && !mode_err));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !(in_valid && sof)) |=> $stable({mode_err, payload_off, seq_num, fcf}));
  // R5
  err_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_err) |-> (payload_off == OFF_W'(3) && !hdr_ok));

endmodule

// File: tb/mac_hdr_filter_bench.sv
module mac_hdr_filter_bench;
  localparam logic [15:0] LPAN   = 16'h1A2B;
  localparam logic [15:0] LSHORT = 16'h0042;
  localparam logic [63:0] LEXT   = 64'h0011_2233_4455_6677;

  logic clk = 0, rst_n = 0, sof = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic done, hdr_ok, mode_err, ack_req, ack_needed, intra_pan;
  logic [2:0] frame_type;
  logic [1:0] dst_mode, src_mode;
  logic [7:0] seq_num;
  logic [4:0] payload_off;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [7:0] fb [0:31];
  int n_hdr;
  logic [15:0] e_fcf;
  logic [7:0]  e_seq;
  logic e_ok, e_err;

  always #10 clk = ~clk;

  mac_hdr_filter u_mac_hdr_filter (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_byte(in_byte),
    .local_pan(LPAN), .local_short(LSHORT), .local_ext(LEXT),
    .done(done), .hdr_ok(hdr_ok), .mode_err(mode_err), .frame_type(frame_type),
    .ack_req(ack_req), .ack_needed(ack_needed), .intra_pan(intra_pan),
    .dst_mode(dst_mode), .src_mode(src_mode), .seq_num(seq_num), .payload_off(payload_off));

  task automatic chk(string r, string what, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, a, e);
    end
  endtask

  function automatic int part_len(logic [1:0] m);
    return (m == 2'd2) ? 4 : (m == 2'd3) ? 10 : 0;
  endfunction

  task automatic build(logic [1:0] dm, logic [1:0] sm, logic intra, logic [2:0] ft, logic ar,
                       int pan_sel, int addr_sel);
    logic [15:0] pan;
    logic [63:0] addr;
    int p;
    e_fcf = {sm, 2'b00, dm, 3'b000, intra, ar, 2'b00, ft};
    e_fcf[4] = $urandom_range(0, 1);
    e_fcf[9:7] = 3'($urandom_range(0, 7));
    e_seq = 8'($urandom);
    pan  = (pan_sel == 0) ? LPAN : (pan_sel == 1) ? 16'hFFFF : 16'($urandom);
    addr = {$urandom, $urandom};
    if (addr_sel == 0) addr = (dm == 2'd2) ? {48'h0, LSHORT} : LEXT;
    if (addr_sel == 1) addr = (dm == 2'd2) ? 64'hFFFF : {$urandom, $urandom};
    if (dm == 2'd2) addr[63:16] = '0;
    for (int i = 0; i < 32; i++) fb[i] = 8'($urandom);
    fb[0] = e_fcf[7:0]; fb[1] = e_fcf[15:8]; fb[2] = e_seq;
    p = 3;
    if (dm >= 2'd2) begin
      fb[3] = pan[7:0]; fb[4] = pan[15:8];
      for (int i = 0; i < part_len(dm) - 2; i++) fb[5 + i] = addr[8*i +: 8];
    end
    if (dm == 2'd1 || sm == 2'd1) begin
      n_hdr = 3;
      e_err = 1;
      e_ok = 0;
    end else begin
      p = 3 + part_len(dm) + part_len(sm);
      if (intra && dm != 0 && sm != 0) p = p - 2;
      n_hdr = p;
      e_err = 0;
      if (dm == 0) e_ok = (sm != 0) || (ft == 3'd2);
      else e_ok = (pan == LPAN || pan == 16'hFFFF) &&
                  ((dm == 2'd2) ? (addr[15:0] == LSHORT || addr[15:0] == 16'hFFFF) : (addr == LEXT));
    end
  endtask

  task automatic check_result();
    chk("R4", "done", done, 1);
    chk("R4", "payload_off", payload_off, n_hdr);
    chk("R5", "mode_err", mode_err, e_err);
    chk("R6/R7/R8", "hdr_ok", hdr_ok, e_ok);
    chk("R9", "ack_needed", ack_needed, e_ok && e_fcf[5]);
    chk("R3", "seq_num", seq_num, e_seq);
    chk("R2", "fields", {frame_type, ack_req, intra_pan, dst_mode, src_mode},
        {e_fcf[2:0], e_fcf[5], e_fcf[6], e_fcf[11:10], e_fcf[15:14]});
  endtask

  task automatic send(int gapmax, int n_pay);
    for (int i = 0; i < n_hdr; i++) begin
      if (i > 0) repeat ($urandom_range(0, gapmax)) begin @(negedge clk); in_valid = 0; end
      @(negedge clk);
      in_valid = 1; sof = (i == 0); in_byte = fb[i];
      if (i == 0 && n_hdr > 1) begin
        @(negedge clk);
        chk("R10", "cleared after start", {done, hdr_ok, mode_err}, 3'b000);
        in_valid = 0; sof = 0;
      end
    end
    @(negedge clk);
    check_result();
    in_valid = 0; sof = 0;
    @(negedge clk);
    chk("R4", "done one cycle", done, 0);
    for (int i = 0; i < n_pay; i++) begin
      repeat ($urandom_range(0, gapmax)) begin @(negedge clk); in_valid = 0; end
      @(negedge clk);
      in_valid = 1; in_byte = 8'($urandom);
    end
    @(negedge clk);
    in_valid = 0;
    if (n_pay > 0) begin
      chk("R11", "no done in payload", done, 0);
      chk("R11", "results held", {hdr_ok, mode_err, payload_off, seq_num}, {e_ok, e_err, 5'(n_hdr), e_seq});
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {done, hdr_ok, mode_err, ack_needed}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "after reset", {done, hdr_ok, mode_err, ack_needed}, 4'b0000);

    // R8: acknowledgment frame with no addresses
    build(2'd0, 2'd0, 0, 3'd2, 0, 0, 0); send(0, 2);
    // R8: data frame with no addresses is rejected
    build(2'd0, 2'd0, 0, 3'd1, 1, 0, 0); send(1, 1);
    // R5: reserved destination mode
    build(2'd1, 2'd2, 0, 3'd1, 1, 0, 0); send(0, 3);
    // R5: reserved source mode
    build(2'd3, 2'd1, 0, 3'd1, 0, 0, 0); send(0, 1);
    // R4: intra-PAN with both short addresses, header length 9
    build(2'd2, 2'd2, 1, 3'd1, 1, 0, 0); send(0, 2);
    // R4/R7: both extended addresses, header length 23
    build(2'd3, 2'd3, 0, 3'd1, 1, 1, 0); send(2, 2);
    // R7: broadcast short address on a foreign PAN is rejected
    build(2'd2, 2'd0, 0, 3'd1, 1, 2, 1); send(0, 0);
    // R10: abandon a frame partway, then send a full one
    build(2'd3, 2'd3, 0, 3'd1, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); in_valid = 1; sof = (i == 0); in_byte = fb[i];
    end
    @(negedge clk); in_valid = 0; sof = 0;
    build(2'd2, 2'd3, 1, 3'd1, 1, 0, 0); send(0, 1);

    for (int f = 0; f < 400; f++) begin
      logic [1:0] dm, sm;
      dm = ($urandom_range(0, 15) == 0) ? 2'd1 : 2'($urandom_range(0, 2) + (($urandom_range(0, 2) == 0) ? 0 : 1));
      if (dm == 2'd1 && $urandom_range(0, 1) == 0) dm = 2'd0;
      sm = ($urandom_range(0, 15) == 0) ? 2'd1 : ($urandom_range(0, 3) == 0) ? 2'd0 : 2'($urandom_range(2, 3));
      build(dm, sm, 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0) ? 3'd2 : 3'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), $urandom_range(0, 2), $urandom_range(0, 2));
      send($urandom_range(0, 2), $urandom_range(0, 4));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule